// File: doc/BRIEF.md
# Dual-Slot Redundant Block Processor

This block drives a time-shared computation engine that has two slots. Slot A holds its registers on the rising clock edge. Slot B holds its registers on the falling edge. Each slot runs a two-stage byte transform, so one pair of operands enters the engine on every rising edge. A dispatcher takes input blocks one at a time over a valid/ready stream and places them into the two slots according to a pairing mode. A result stage then either forwards the results or checks them against each other.

The block has three pairing modes:

- Throughput mode puts two different blocks in each pair and does no checking.
- Duplicate mode puts the same block in both slots and compares the two results.
- Interleaved mode puts the previous block in slot A and the new block in slot B. The repeat of one block is checked against the first computation of that same block, which ran one pair earlier in slot B. A dummy operand fills the unused slot at the start and at the end of a stream. This mode suits a run of blocks that share one key.

When a comparison fails, the block sets a sticky error flag, drops `in_ready` and emits nothing more until reset. The input stream uses valid/ready back-pressure: a block is taken on a rising edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must hold its block steady. The output has no ready signal; a result is present for exactly one cycle while `out_valid` is high. A test input, `fault_xor`, XORs a pattern into the slot B first-stage result so that a fault can be provoked on purpose.

Top module: `dual_slot_checker`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err` is 0.
- R2: Each byte b of a block becomes ((b rotated left by one) XOR 0x5A) + 0x17 mod 256. Bytes do not affect one another. A result is driven after the third rising edge that follows the edge launching its pair.
- R3: In throughput mode (`mode` = 2'b00), blocks that arrive one after another are paired. The pair is emitted once, with `out_both` = 1, the earlier block on `out_data0` and the later block on `out_data1`. No comparison is made.
- R4: In throughput mode, a block taken with `in_last` = 1 while no partner is held is emitted alone, with `out_both` = 0 on `out_data0`.
- R5: In duplicate mode (`mode` = 2'b01), each block fills both slots. Its result is emitted once on `out_data0` with `out_both` = 0, and only if the two slot results match.
- R6: In interleaved mode (`mode` = 2'b10), the pairs run (dummy,B1), (B1,B2) … (Bn,dummy). A block taken with `in_last` = 1 closes the stream. Every block is emitted once, in order, on `out_data0` with `out_both` = 0. The dummy result is never compared or emitted.
- R7: In interleaved mode, `in_ready` is 0 in the cycle after a block with `in_last` = 1 is taken, while the closing pair is launched.
- R8: `mode` is sampled only while no stream is open, meaning neither a throughput half-pair nor an unfinished interleaved stream is pending. A change while a stream is open has no effect on that stream.
- R9: `mode` = 2'b11 behaves as duplicate mode.
- R10: `fault_xor` is XORed into the slot B first-stage result. In throughput mode this corrupts `out_data1` only and never sets `err`.
- R11: A mismatch in duplicate or interleaved mode sets `err`, and the failing block is not emitted. `err` stays set until reset.
- R12: While `err` is set, `in_ready` is 0 and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Slot A uses the rising edge, slot B the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Pairing mode: 00 throughput, 01 duplicate, 10 interleaved, 11 duplicate |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block accepted on this edge if `in_valid` is high |
| in_data | input | 32 | Input block |
| in_last | input | 1 | Marks the final block of a stream |
| fault_xor | input | 32 | Test pattern XORed into the slot B first-stage result |
| out_valid | output | 1 | Result present this cycle |
| out_both | output | 1 | Both data lanes carry results (throughput pairs) |
| out_data0 | output | 32 | First result lane |
| out_data1 | output | 32 | Second result lane, valid when `out_both` is 1 |
| err | output | 1 | Sticky mismatch flag |

## Verification
Throughput mode is driven with even and odd stream lengths. This separates the paired emission from the lone-block flush, and a fault pattern on slot B shows that this mode has no comparison. Duplicate and interleaved streams of one and of several blocks show that each block is emitted exactly once and in order, that the dummy slot stays silent, and that the closing pair stalls the input for one cycle. A mode change in the middle of a stream and the reserved mode code test the mode latch. Faults injected in duplicate and interleaved modes test the sticky halt: no output and no further acceptance.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    MODE_THRU  = 2'b00,
    MODE_DUP   = 2'b01,
    MODE_INTLV = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PK_ONE  = 3'd0,  // throughput, lane A only
    PK_TWO  = 3'd1,  // throughput, both lanes
    PK_DUP  = 3'd2,  // same block twice, compare A and B
    PK_HEAD = 3'd3,  // dummy in A, first block in B
    PK_MID  = 3'd4,  // repeat in A, new block in B
    PK_TAIL = 3'd5   // repeat in A, dummy in B
  } pair_kind_e;

  function automatic logic [7:0] stage1_byte(input logic [7:0] b);
    return {b[6:0], b[7]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] stage2_byte(input logic [7:0] b);
    return b + 8'h17;
  endfunction

endpackage

// File: rtl/dsc_dispatch.sv
module dsc_dispatch
  import dsc_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [BW-1:0] in_data,
  input  logic       in_last,
  input  logic       halt,
  output logic       p_vld,
  output pair_kind_e p_kind,
  output logic [BW-1:0] p_a,
  output logic [BW-1:0] p_b
);

  mode_e         mode_q, eff_mode;
  logic          hold_vld, open_q, tail_pend, idle, acc;
  logic [BW-1:0] hold_q, prev_q;
  logic          launch;
  pair_kind_e    l_kind;
  logic [BW-1:0] l_a, l_b;

  assign idle     = !hold_vld && !open_q && !tail_pend;
  assign eff_mode = idle ? mode_e'(mode) : mode_q;
  assign in_ready = !halt && !tail_pend;
  assign acc      = in_valid && in_ready;

  always_comb begin
    launch = 1'b0;
    l_kind = PK_DUP;
    l_a    = '0;
    l_b    = '0;
    if (!halt) begin
      if (tail_pend) begin
        launch = 1'b1;
        l_kind = PK_TAIL;
        l_a    = prev_q;
      end else if (acc) begin
        case (eff_mode)
          MODE_THRU: begin
            if (hold_vld) begin
              launch = 1'b1; l_kind = PK_TWO; l_a = hold_q; l_b = in_data;
            end else if (in_last) begin
              launch = 1'b1; l_kind = PK_ONE; l_a = in_data;
            end
          end
          MODE_INTLV: begin
            launch = 1'b1;
            l_kind = open_q ? PK_MID : PK_HEAD;
            l_a    = open_q ? prev_q : '0;
            l_b    = in_data;
          end
          default: begin
            launch = 1'b1; l_kind = PK_DUP; l_a = in_data; l_b = in_data;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_THRU;
      hold_vld  <= 1'b0;
      open_q    <= 1'b0;
      tail_pend <= 1'b0;
      hold_q    <= '0;
      prev_q    <= '0;
      p_vld     <= 1'b0;
      p_kind    <= PK_DUP;
      p_a       <= '0;
      p_b       <= '0;
    end else begin
      if (idle) mode_q <= mode_e'(mode);
      p_vld <= launch;
      if (launch) begin
        p_kind <= l_kind;
        p_a    <= l_a;
        p_b    <= l_b;
      end
      if (!halt) begin
        if (tail_pend) begin
          tail_pend <= 1'b0;
          open_q    <= 1'b0;
        end else if (acc) begin
          case (eff_mode)
            MODE_THRU: begin
              if (hold_vld) hold_vld <= 1'b0;
              else if (!in_last) begin
                hold_vld <= 1'b1;
                hold_q   <= in_data;
              end
            end
            MODE_INTLV: begin
              prev_q <= in_data;
              open_q <= 1'b1;
              if (in_last) tail_pend <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mode_q)) else $error("mode changed mid-stream");  // R8
  AST_HALT_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !p_vld) else $error("pair launched while halted");  // R12
  AST_TAIL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last && eff_mode == MODE_INTLV) |=> !in_ready) else $error("no stall for closing pair");  // R7

endmodule

// File: rtl/dsc_slot_engine.sv
module dsc_slot_engine
  import dsc_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int BW = NBYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_vld,
  input  pair_kind_e    p_kind,
  input  logic [BW-1:0] p_a,
  input  logic [BW-1:0] p_b,
  input  logic [BW-1:0] fault_xor,
  output logic          r_vld,
  output pair_kind_e    r_kind,
  output logic [BW-1:0] r_a,
  output logic [BW-1:0] r_b
);

  logic [BW-1:0] a_t1, a_t2, b_t1, b_t2;
  logic [BW-1:0] a_s1, a_s2;   // rising-edge slot
  logic [BW-1:0] b_s1, b_s2;   // falling-edge slot
  logic [BW-1:0] b_sync;
  logic          v1, v2;
  pair_kind_e    k1, k2;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign a_t1[g*8 +: 8] = stage1_byte(p_a[g*8 +: 8]);
    assign b_t1[g*8 +: 8] = stage1_byte(p_b[g*8 +: 8]) ^ fault_xor[g*8 +: 8];
    assign a_t2[g*8 +: 8] = stage2_byte(a_s1[g*8 +: 8]);
    assign b_t2[g*8 +: 8] = stage2_byte(b_s1[g*8 +: 8]);
  end

  always_ff @(negedge clk) begin
    b_s1 <= b_t1;
    b_s2 <= b_t2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      k1 <= PK_DUP;
      k2 <= PK_DUP;
    end else begin
      v1 <= p_vld;
      v2 <= v1;
      k1 <= p_kind;
      k2 <= k1;
    end
    a_s1   <= a_t1;
    a_s2   <= a_t2;
    b_sync <= b_s2;
  end

  assign r_vld  = v2;
  assign r_kind = k2;
  assign r_a    = a_s2;
  assign r_b    = b_sync;

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    p_vld |=> ##1 r_vld) else $error("result slot lost");  // R2

endmodule

// File: rtl/dsc_compare.sv
module dsc_compare
  import dsc_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          r_vld,
  input  pair_kind_e    r_kind,
  input  logic [BW-1:0] r_a,
  input  logic [BW-1:0] r_b,
  output logic          out_valid,
  output logic          out_both,
  output logic [BW-1:0] out_data0,
  output logic [BW-1:0] out_data1,
  output logic          err
);

  logic [BW-1:0] saved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_both  <= 1'b0;
      out_data0 <= '0;
      out_data1 <= '0;
      err       <= 1'b0;
      saved_q   <= '0;
    end else begin
      out_valid <= 1'b0;
      out_both  <= 1'b0;
      if (r_vld && !err) begin
        case (r_kind)
          PK_ONE: begin
            out_valid <= 1'b1; out_data0 <= r_a;
          end
          PK_TWO: begin
            out_valid <= 1'b1; out_both <= 1'b1;
            out_data0 <= r_a;  out_data1 <= r_b;
          end
          PK_HEAD: saved_q <= r_b;
          PK_MID: begin
            saved_q <= r_b;
            if (r_a != saved_q) err <= 1'b1;
            else begin out_valid <= 1'b1; out_data0 <= r_a; end
          end
          PK_TAIL: begin
            if (r_a != saved_q) err <= 1'b1;
            else begin out_valid <= 1'b1; out_data0 <= r_a; end
          end
          default: begin
            if (r_a != r_b) err <= 1'b1;
            else begin out_valid <= 1'b1; out_data0 <= r_a; end
          end
        endcase
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err) else $error("error flag cleared");  // R11
  AST_SILENT_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid) else $error("output while halted");  // R12
  AST_DUMMY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_vld && r_kind == PK_HEAD) |=> !out_valid) else $error("dummy emitted");  // R6
  AST_DUP_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (r_vld && r_kind == PK_DUP && r_a != r_b) |=> (err && !out_valid)) else $error("mismatch missed");  // R11

endmodule

// File: rtl/dual_slot_checker.sv
module dual_slot_checker
  import dsc_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int BW = NBYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_data,
  input  logic          in_last,
  input  logic [BW-1:0] fault_xor,
  output logic          out_valid,
  output logic          out_both,
  output logic [BW-1:0] out_data0,
  output logic [BW-1:0] out_data1,
  output logic          err
);

  logic          p_vld, r_vld;
  pair_kind_e    p_kind, r_kind;
  logic [BW-1:0] p_a, p_b, r_a, r_b;

  dsc_dispatch #(.BW(BW)) u_dispatch (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .halt(err),
    .p_vld(p_vld), .p_kind(p_kind), .p_a(p_a), .p_b(p_b)
  );

  dsc_slot_engine #(.NBYTES(NBYTES)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .p_vld(p_vld), .p_kind(p_kind), .p_a(p_a), .p_b(p_b), .fault_xor(fault_xor),
    .r_vld(r_vld), .r_kind(r_kind), .r_a(r_a), .r_b(r_b)
  );

  dsc_compare #(.BW(BW)) u_compare (
    .clk(clk), .rst_n(rst_n),
    .r_vld(r_vld), .r_kind(r_kind), .r_a(r_a), .r_b(r_b),
    .out_valid(out_valid), .out_both(out_both),
    .out_data0(out_data0), .out_data1(out_data1), .err(err)
  );

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready) else $error("input accepted while halted");  // R12

endmodule

// File: tb/dual_slot_checker_bench.sv
module dual_slot_checker_bench;

  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic [BW-1:0] fault_xor = '0;
  logic          out_valid, out_both, err;
  logic [BW-1:0] out_data0, out_data1;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic          both;
    logic [BW-1:0] d0;
    logic [BW-1:0] d1;
    string         req;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;  // 125 MHz

  dual_slot_checker u_dual_slot_checker (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .fault_xor(fault_xor),
    .out_valid(out_valid), .out_both(out_both),
    .out_data0(out_data0), .out_data1(out_data1), .err(err)
  );

  function automatic logic [BW-1:0] model(input logic [BW-1:0] x, input logic [BW-1:0] f);
    logic [BW-1:0] r;
    for (int i = 0; i < BW/8; i++) begin
      logic [7:0] b;
      b = x[i*8 +: 8];
      b = ((b << 1) | (b >> 7)) ^ 8'h5A;
      b = b ^ f[i*8 +: 8];
      r[i*8 +: 8] = b + 8'h17;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic both, input logic [BW-1:0] d0, input logic [BW-1:0] d1, input string req);
    exp_t e;
    e.both = both; e.d0 = d0; e.d1 = d1; e.req = req;
    expq.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R12 unexpected output", {32'h0, out_data0}, 64'h0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(out_both == e.both, {e.req, " lane count"}, {63'h0, out_both}, {63'h0, e.both});
        chk(out_data0 == e.d0, {e.req, " data0"}, {32'h0, out_data0}, {32'h0, e.d0});
        if (e.both) chk(out_data1 == e.d1, {e.req, " data1"}, {32'h0, out_data1}, {32'h0, e.d1});
      end
    end
  end

  task automatic send(input logic [BW-1:0] d, input logic last);
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, {req, " all results seen"}, 64'(expq.size()), 64'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; fault_xor = '0;
    expq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", {63'h0, in_ready}, 64'h1);
    chk(out_valid == 1'b0, "R1 out_valid", {63'h0, out_valid}, 64'h0);
    chk(err == 1'b0, "R1 err", {63'h0, err}, 64'h0);

    // R3 throughput pairs, R2 transform
    mode = 2'b00;
    push(1, model(32'h0011_2233, 0), model(32'h80FF_7F01, 0), "R3");
    push(1, model(32'hDEAD_BEEF, 0), model(32'h1234_5678, 0), "R2");
    send(32'h0011_2233, 0); send(32'h80FF_7F01, 0);
    send(32'hDEAD_BEEF, 0); send(32'h1234_5678, 1);
    drain("R3");

    // R4 odd stream
    push(1, model(32'hA5A5_A5A5, 0), model(32'h0F0F_0F0F, 0), "R4");
    push(0, model(32'hFFFF_0000, 0), '0, "R4");
    send(32'hA5A5_A5A5, 0); send(32'h0F0F_0F0F, 0); send(32'hFFFF_0000, 1);
    drain("R4");

    // R5 duplicate
    mode = 2'b01;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      push(0, model(32'h1357_9BDF + i, 0), '0, "R5");
      send(32'h1357_9BDF + i, 0);
    end
    drain("R5");
    chk(err == 1'b0, "R5 no error on match", {63'h0, err}, 64'h0);

    // R9 reserved code
    mode = 2'b11;
    @(negedge clk);
    push(0, model(32'h0BAD_CAFE, 0), '0, "R9");
    send(32'h0BAD_CAFE, 0);
    drain("R9");

    // R6 interleaved, several blocks; R7 stall
    mode = 2'b10;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      push(0, model(32'h4000_0001 * (i + 3), 0), '0, "R6");
      send(32'h4000_0001 * (i + 3), i == 3);
    end
    chk(in_ready == 1'b0, "R7 stall after last", {63'h0, in_ready}, 64'h0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready returns", {63'h0, in_ready}, 64'h1);
    drain("R6");

    // R6 one-block interleaved stream
    push(0, model(32'h7766_5544, 0), '0, "R6 single");
    send(32'h7766_5544, 1);
    drain("R6 single");
    chk(err == 1'b0, "R6 dummy not compared", {63'h0, err}, 64'h0);

    // R8 mode change mid-stream ignored
    mode = 2'b00;
    @(negedge clk);
    push(1, model(32'h1111_2222, 0), model(32'h3333_4444, 0), "R8");
    send(32'h1111_2222, 0);
    mode = 2'b01;
    send(32'h3333_4444, 1);
    drain("R8");

    // R10 fault in throughput mode: lane 1 corrupted, no error
    mode = 2'b00;
    fault_xor = 32'h0000_0100;
    @(negedge clk);
    push(1, model(32'h5555_6666, 0), model(32'h7777_8888, 32'h0000_0100), "R10");
    send(32'h5555_6666, 0); send(32'h7777_8888, 1);
    drain("R10");
    chk(err == 1'b0, "R10 no error", {63'h0, err}, 64'h0);
    fault_xor = '0;

    // R11/R12 duplicate mismatch
    mode = 2'b01;
    @(negedge clk);
    fault_xor = 32'h0000_0001;
    send(32'hCAFE_F00D, 0);
    repeat (8) @(negedge clk);
    chk(err == 1'b1, "R11 err set", {63'h0, err}, 64'h1);
    chk(in_ready == 1'b0, "R12 ready low", {63'h0, in_ready}, 64'h0);
    in_valid = 1'b1; in_data = 32'h2468_ACE0;
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    chk(err == 1'b1, "R11 err sticky", {63'h0, err}, 64'h1);
    chk(out_valid == 1'b0, "R12 no output", {63'h0, out_valid}, 64'h0);

    // R11 interleaved mismatch
    do_reset();
    chk(err == 1'b0, "R1 err cleared by reset", {63'h0, err}, 64'h0);
    mode = 2'b10;
    fault_xor = 32'h0100_0000;
    @(negedge clk);
    send(32'h0102_0304, 0);
    send(32'h0506_0708, 1);
    repeat (10) @(negedge clk);
    chk(err == 1'b1, "R11 interleaved err", {63'h0, err}, 64'h1);
    chk(in_ready == 1'b0, "R12 ready low interleaved", {63'h0, in_ready}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule